// File: doc/BRIEF.md
# Slot-Masked TDM Serial Receiver

This block receives a time-division multiplexed serial stream. It runs on a continuous bit clock, and a one-bit-wide frame sync marks the first bit of each frame. The block assembles fixed-length words, most significant bit first, and counts the time slots inside each frame.

A per-slot enable mask decides what happens to each completed word. In an enabled slot, the word is written to the receive data register and the receive-full flag is set. If interrupts are enabled, the block also raises an interrupt.

In a disabled slot, the word is thrown away. The data register, the flags and the interrupt line do not change. With only a few slots enabled, software sees one interrupt per wanted word rather than one per slot.

Top module: `slot_rx`

## Requirements
- R1: After reset, `rdata` is 0 and `rx_full`, `overrun` and `irq` are 0.
- R2: The block samples `sdata` on each rising `clk` edge. The bit sampled while `fsync` is high is the MSB of slot 0. Each word takes WORD_W consecutive bits, MSB first, and an enabled word appears on `rdata` after the edge that samples its last bit.
- R3: If a slot's mask bit is 0, its completed word leaves `rdata`, `rx_full`, `overrun` and `irq` unchanged.
- R4: With every mask bit set to 1, every slot of the frame is delivered in order.
- R5: An enabled transfer sets `rx_full`. A `rd_strobe` sampled on a rising edge clears it. If both happen on the same edge, the transfer wins.
- R6: If an enabled word completes while `rx_full` is set and no read is sampled, `overrun` is set and the new word replaces `rdata`. A read clears `overrun`.
- R7: `irq` is high exactly when `rx_full` and `irq_en` are both high.
- R8: Slot indexes run from 0 to NSLOTS-1 and wrap to 0. The word in slot n uses `slot_mask[n]`. A frame sync in the middle of a word discards the partial word and restarts the frame at slot 0.
- R9: Before the first frame sync after reset, no word is captured.
- R10: With NSLOTS=5 and mask 5'b01001 (slots 0 and 3), exactly two transfers and two interrupt events occur per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Continuous bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame sync, high during the first bit of slot 0 |
| sdata | input | 1 | Serial receive data |
| slot_mask | input | NSLOTS | Per-slot enable, bit n for slot n |
| irq_en | input | 1 | Interrupt enable |
| rd_strobe | input | 1 | Data register read, one cycle |
| rdata | output | WORD_W | Receive data register |
| rx_full | output | 1 | Receive data register holds an unread word |
| overrun | output | 1 | An unread word was overwritten |
| irq | output | 1 | Receive interrupt |

## Verification
The assertions check the following on every cycle:
- a masked completion leaves the data and both flags untouched;
- an enabled completion always sets `rx_full`, and sets `overrun` when the old word was unread;
- a lone read clears the full flag;
- the slot index stays in range;
- nothing is flagged before the first frame sync.

The order in which words are assembled, MSB first, can only be shown by the bench's scenarios, which compare each delivered word against a queue of expected words. The same applies to the wrap of slot indexes and the restart after an early frame sync. The bench also counts two transfers per frame with a sparse mask.

// File: rtl/slot_rx.sv
module slot_rx #(
  parameter int WORD_W = 8,
  parameter int NSLOTS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic              sdata,
  input  logic [NSLOTS-1:0] slot_mask,
  input  logic              irq_en,
  input  logic              rd_strobe,
  output logic [WORD_W-1:0] rdata,
  output logic              rx_full,
  output logic              overrun,
  output logic              irq
);
  localparam int BW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam int SW = (NSLOTS > 1) ? $clog2(NSLOTS) : 1;
  localparam logic [BW-1:0] LAST_BIT  = BW'(WORD_W - 1);
  localparam logic [SW-1:0] LAST_SLOT = SW'(NSLOTS - 1);

  logic [WORD_W-1:0] sh;
  logic [BW-1:0]     bit_cnt;
  logic [SW-1:0]     slot;
  logic              synced;

  wire [WORD_W-1:0] word_in   = {sh[WORD_W-2:0], sdata};
  wire              word_done = synced && !fsync && (bit_cnt == LAST_BIT);
  wire              take      = word_done && slot_mask[slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh      <= '0;
      bit_cnt <= '0;
      slot    <= '0;
      synced  <= 1'b0;
    end else begin
      sh <= word_in;
      if (fsync) begin
        synced  <= 1'b1;
        bit_cnt <= BW'(1);
        slot    <= '0;
      end else if (word_done) begin
        bit_cnt <= '0;
        slot    <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
      end else if (synced) begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata   <= '0;
      rx_full <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (take) rdata <= word_in;
      rx_full <= take | (rx_full & ~rd_strobe);
      overrun <= (take & rx_full & ~rd_strobe) | (overrun & ~rd_strobe);
    end
  end

  assign irq = rx_full & irq_en;
endmodule

// File: rtl/slot_rx_chk.sv
module slot_rx_chk #(
  parameter int WORD_W = 8,
  parameter int NSLOTS = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rd_strobe,
  input logic [NSLOTS-1:0]      slot_mask,
  input logic [WORD_W-1:0]      rdata,
  input logic                   rx_full,
  input logic                   overrun,
  input logic                   word_done,
  input logic                   synced,
  input logic [((NSLOTS > 1) ? $clog2(NSLOTS) : 1)-1:0] slot
);
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && !slot_mask[slot] && !rd_strobe |=> $stable(rdata) && $stable(rx_full) && $stable(overrun)); // R3
  AST_TAKE_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && slot_mask[slot] |=> rx_full); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && !word_done |=> !rx_full); // R5
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && slot_mask[slot] && rx_full && !rd_strobe |=> overrun); // R6
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(slot) < NSLOTS); // R8
  AST_NO_SYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> !rx_full && !overrun); // R9
endmodule

bind slot_rx slot_rx_chk #(.WORD_W(WORD_W), .NSLOTS(NSLOTS)) u_chk (.*);

// File: tb/tb_slot_rx.sv
`timescale 1ns/1ps
module tb_slot_rx;
  localparam int W = 8;
  localparam int N = 5;

  logic clk = 0, rst_n = 0, fsync = 0, sdata = 0, irq_en = 0, rd_strobe = 0;
  logic [N-1:0] slot_mask = '1;
  logic [W-1:0] rdata;
  logic rx_full, overrun, irq;

  always #2.5 clk = ~clk;

  slot_rx #(.WORD_W(W), .NSLOTS(N)) dut (.*);

  int checks = 0, fails = 0, pops = 0;
  bit mon_en = 0;
  logic [W-1:0] expq[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [W-1:0] w, input bit first, input int nbits);
    for (int b = 0; b < nbits; b++) begin
      @(negedge clk);
      fsync = first && (b == 0);
      sdata = w[W-1-b];
    end
  endtask

  task automatic send_frame(input logic [W-1:0] base, input int nwords, input bit push);
    for (int i = 0; i < nwords; i++) begin
      logic [W-1:0] w;
      w = base + W'(i * 37);
      if (push && slot_mask[i % N]) expq.push_back(w);
      send_word(w, i == 0, W);
    end
    @(negedge clk);
    fsync = 0;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (mon_en && rx_full) begin
        logic [W-1:0] e;
        if (expq.size() == 0) begin
          chk(0, "R3 unexpected word", int'(rdata), 0);
        end else begin
          e = expq.pop_front();
          chk(rdata == e, "R2 word", int'(rdata), int'(e));
          chk(irq == irq_en, "R7 irq", int'(irq), int'(irq_en));
        end
        pops++;
        rd_strobe = 1;
        @(negedge clk);
        rd_strobe = 0;
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(rdata == 0, "R1 rdata", int'(rdata), 0);
    chk(rx_full == 0, "R1 rx_full", int'(rx_full), 0);
    chk(overrun == 0, "R1 overrun", int'(overrun), 0);
    chk(irq == 0, "R1 irq", int'(irq), 0);
    rst_n = 1;

    // R9: bits with no frame sync are ignored
    for (int i = 0; i < 20; i++) begin @(negedge clk); sdata = i[0]; end
    @(negedge clk);
    chk(rx_full == 0, "R9 no capture", int'(rx_full), 0);

    // R4: all slots enabled
    irq_en = 1; mon_en = 1; slot_mask = '1; pops = 0;
    send_frame(8'hA5, N, 1);
    repeat (3) @(negedge clk);
    chk(pops == N, "R4 all slots", pops, N);
    chk(expq.size() == 0, "R4 queue empty", expq.size(), 0);

    // R10 / R3: slots 0 and 3 only
    slot_mask = 5'b01001;
    for (int f = 0; f < 2; f++) begin
      pops = 0;
      send_frame(8'h3C + W'(f), N, 1);
      repeat (3) @(negedge clk);
      chk(pops == 2, "R10 two per frame", pops, 2);
      chk(rx_full == 0 && rdata == 8'h3C + W'(f) + W'(3 * 37), "R3 masked slot quiet", int'(rdata), int'(8'h3C + W'(f) + W'(3*37)));
    end

    // R8: slot index wraps; slot 1 hit twice in 7 words
    slot_mask = 5'b00010; pops = 0;
    send_frame(8'h11, 7, 1);
    repeat (3) @(negedge clk);
    chk(pops == 2, "R8 wrap", pops, 2);

    // R8: frame sync mid-word restarts at slot 0
    slot_mask = 5'b00001; pops = 0;
    send_word(8'hFF, 1, 3);
    send_frame(8'h5A, 2, 1);
    repeat (3) @(negedge clk);
    chk(pops == 1, "R8 restart", pops, 1);
    chk(expq.size() == 0, "R8 queue empty", expq.size(), 0);

    // R6 / R7: no reads, overrun
    mon_en = 0; irq_en = 0; slot_mask = '1;
    send_frame(8'h20, N, 0);
    @(negedge clk);
    chk(rx_full == 1, "R5 full held", int'(rx_full), 1);
    chk(overrun == 1, "R6 overrun", int'(overrun), 1);
    chk(rdata == 8'h20 + W'(4 * 37), "R6 overwrite", int'(rdata), int'(8'h20 + W'(4*37)));
    chk(irq == 0, "R7 irq masked", int'(irq), 0);
    irq_en = 1;
    @(negedge clk);
    chk(irq == 1, "R7 irq enabled", int'(irq), 1);
    rd_strobe = 1;
    @(negedge clk);
    rd_strobe = 0;
    chk(rx_full == 0, "R5 read clears", int'(rx_full), 0);
    chk(overrun == 0, "R6 read clears overrun", int'(overrun), 0);

    // R5: read on the same edge as a transfer, transfer wins
    slot_mask = 5'b00011;
    send_word(8'h77, 1, W);
    @(negedge clk);
    fsync = 0;
    chk(rx_full == 1, "R5 first word", int'(rx_full), 1);
    for (int b = 0; b < W; b++) begin
      rd_strobe = (b == W - 1);
      sdata = b[0];
      @(negedge clk);
    end
    rd_strobe = 0;
    chk(rx_full == 1 && overrun == 0, "R5 transfer wins", int'({rx_full, overrun}), 2);
    chk(rdata == 8'h55, "R2 MSB first", int'(rdata), 8'h55);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule